// File: doc/BRIEF.md
# Linked-Descriptor Frame Fetcher

This block supplies a display pipeline with raw frame-buffer words. It walks a chain of descriptors that sit in system memory. Each descriptor gives a link to the next descriptor, the start address of a frame buffer, a frame tag and a command word. The command word carries a word count, per-frame interrupt requests and a palette marker. The block reads the descriptor, then fetches that many 32-bit words from the buffer in bursts whose size software selects. The words pass through an internal FIFO to a valid/ready output stream. After the last word the block follows the link. A descriptor that links to itself therefore repeats its frame with no software work.

Software writes the address of the first descriptor into a pointer register and then sets the enable bit. Start-of-frame, end-of-frame and output-underrun events set sticky status bits, each gated by its own enable. Software clears a status bit by writing 1 to it. The interrupt line is the OR of the status bits. The buffer address, tag and command of the descriptor most recently loaded can be read back.

Top module: `frame_desc_fetcher`

## Requirements
- R1: After reset, out_valid, mem_req and irq are low, and the control (index 0) and status (index 2) registers read 0.
- R2: A descriptor is four words at consecutive addresses, in this order: link, buffer address, tag, command. Once the command word arrives, reads at register index 3, 4 and 5 return that descriptor's buffer address, tag and command.
- R3: The block streams exactly command[23:0] words, in address order, from the buffer address. A count of 0 fetches no data.
- R4: After the last word of a frame, or straight after the command word when the count is 0, the block fetches the descriptor at the link address. A self-link repeats the frame indefinitely.
- R5: Control bits 29:28 set the burst size: 0 gives 4 words, 1 gives 8 words, 2 or 3 give 16 words. A request keeps its address and length stable until it is granted, and each word then returns as one mem_rvalid beat.
- R6: The last burst of a frame is cut to the words that remain, so no word past the count is read.
- R7: Status bit 0 is set at a command word that has bit 31 set, when control bit 12 is set. Status bit 1 is set when the last word of a frame that has command bit 30 set arrives, when control bit 13 is set.
- R8: Status bit 2 is set when out_ready is high while the FIFO is empty during a frame's data phase, and only when control bit 11 is set. Without bit 11 the condition has no effect.
- R9: Writing 1 to a status bit at index 2 clears it. irq is high exactly when some status bit is set.
- R10: out_pal carries command bit 28 of the descriptor that each word belongs to.
- R11: Clearing control bit 0 stops fetching at the end of the current burst or descriptor read, never in the middle of one. Setting it again restarts from the pointer register (index 1).
- R12: A data burst is requested only when the FIFO has room for the whole burst. The output keeps word order under any out_ready pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_req | output | 1 | Burst read request |
| mem_addr | output | 32 | Byte address of the first word |
| mem_len | output | 5 | Burst length in words |
| mem_gnt | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read data beat |
| mem_rdata | input | 32 | Read data |
| out_valid | output | 1 | Output word available |
| out_data | output | 32 | Output word |
| out_pal | output | 1 | Word belongs to a palette-load frame |
| out_ready | input | 1 | Consumer accepts a word |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check these rules on every cycle: a pending request holds its address and length until granted, a data burst never asks for more words than remain, the FIFO never overflows or underflows, and a status bit rises only while its control enable is set and falls after a write-1 clear. Other behaviour shows only in the bench scenarios: the exact word sequence and palette marking across a chained pair of frames, the shortened last burst for each burst size, a self-linked frame that repeats until the block is disabled, the shadow registers after a chain ends, and a disable that leaves the memory port idle.

// File: rtl/fdf_pkg.sv
`timescale 1ns/1ps
package fdf_pkg;

    localparam int MAX_BURST = 16;
    localparam int BLEN_W    = $clog2(MAX_BURST + 1);

    // control register bit positions
    localparam int CTL_RUN    = 0;
    localparam int CTL_UNF_IE = 11;
    localparam int CTL_SOF_IE = 12;
    localparam int CTL_EOF_IE = 13;
    localparam int CTL_BSZ_LO = 28;
    localparam logic [31:0] CTL_MASK = 32'h3000_3801;

    // command word flags
    localparam int CMD_SOF = 31;
    localparam int CMD_EOF = 30;
    localparam int CMD_PAL = 28;

    // status bits
    localparam int STS_SOF = 0;
    localparam int STS_EOF = 1;
    localparam int STS_UNF = 2;

    // register indices
    localparam logic [2:0] RX_CTRL = 3'd0;
    localparam logic [2:0] RX_PTR  = 3'd1;
    localparam logic [2:0] RX_STS  = 3'd2;
    localparam logic [2:0] RX_SBUF = 3'd3;
    localparam logic [2:0] RX_STAG = 3'd4;
    localparam logic [2:0] RX_SCMD = 3'd5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DREQ,
        ST_DBEAT,
        ST_FREQ,
        ST_FBEAT
    } fdf_state_e;

    function automatic logic [BLEN_W-1:0] burst_words(input logic [1:0] sel);
        case (sel)
            2'd0:    return BLEN_W'(4);
            2'd1:    return BLEN_W'(8);
            default: return BLEN_W'(16);
        endcase
    endfunction

endpackage

// File: rtl/fdf_fifo.sv
`timescale 1ns/1ps
module fdf_fifo #(
    parameter int W     = 33,
    parameter int DEPTH = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [W-1:0]                 wdata,
    input  logic                         pop,
    output logic [W-1:0]                 rdata,
    output logic                         empty,
    output logic                         full,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_t;

    fifo_t q, d;
    logic [W-1:0] store_q [DEPTH];

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        d = q;
        if (push) d.wp = step(q.wp);
        if (pop)  d.rp = step(q.rp);
        d.cnt = q.cnt + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (push) store_q[q.wp] <= wdata;
    end

    assign rdata = store_q[q.rp];
    assign empty = (q.cnt == '0);
    assign full  = (q.cnt == CW'(DEPTH));
    assign count = q.cnt;

    p_no_overflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full)
        else $error("fifo written while full");

    p_no_underflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty)
        else $error("fifo read while empty");

endmodule

// File: rtl/fdf_engine.sv
`timescale 1ns/1ps
module fdf_engine
    import fdf_pkg::*;
#(
    parameter int LEN_W      = 24,
    parameter int FIFO_DEPTH = 32
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               run,
    input  logic [1:0]                         burst_sel,
    input  logic [31:0]                        desc_ptr,
    input  logic [$clog2(FIFO_DEPTH+1)-1:0]    fifo_cnt,
    output logic                               mem_req,
    output logic [31:0]                        mem_addr,
    output logic [BLEN_W-1:0]                  mem_len,
    input  logic                               mem_gnt,
    input  logic                               mem_rvalid,
    input  logic [31:0]                        mem_rdata,
    output logic                               push,
    output logic                               push_pal,
    output logic                               sof_evt,
    output logic                               eof_evt,
    output logic                               frame_active,
    output logic [31:0]                        sh_buf,
    output logic [31:0]                        sh_tag,
    output logic [31:0]                        sh_cmd
);
    localparam int CW = $clog2(FIFO_DEPTH + 1);

    typedef struct packed {
        fdf_state_e        st;
        logic [31:0]       desc;
        logic [31:0]       link;
        logic [31:0]       buf_a;
        logic [31:0]       tag_t;
        logic [31:0]       sh_buf;
        logic [31:0]       sh_tag;
        logic [31:0]       sh_cmd;
        logic [LEN_W-1:0]  remain;
        logic [BLEN_W-1:0] blen;
        logic [BLEN_W-1:0] left;
        logic [1:0]        idx;
        logic              pal;
        logic              eof_f;
    } eng_t;

    eng_t q, d;
    logic [BLEN_W-1:0] bw;
    logic [CW-1:0]     room;
    logic [LEN_W-1:0]  cmd_len;

    function automatic logic [BLEN_W-1:0] clip(input logic [LEN_W-1:0] rem,
                                               input logic [BLEN_W-1:0] b);
        return (rem < LEN_W'(b)) ? rem[BLEN_W-1:0] : b;
    endfunction

    assign bw      = burst_words(burst_sel);
    assign room    = CW'(FIFO_DEPTH) - fifo_cnt;
    assign cmd_len = mem_rdata[LEN_W-1:0];

    always_comb begin
        d        = q;
        mem_req  = 1'b0;
        mem_addr = q.desc;
        mem_len  = BLEN_W'(4);
        push     = 1'b0;
        sof_evt  = 1'b0;
        eof_evt  = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (run) begin
                    d.desc = {desc_ptr[31:2], 2'b00};
                    d.st   = ST_DREQ;
                end
            end
            ST_DREQ: begin
                mem_req = 1'b1;
                if (mem_gnt) begin
                    d.idx = 2'd0;
                    d.st  = ST_DBEAT;
                end
            end
            ST_DBEAT: begin
                if (mem_rvalid) begin
                    d.idx = q.idx + 2'd1;
                    case (q.idx)
                        2'd0: d.link  = {mem_rdata[31:2], 2'b00};
                        2'd1: d.buf_a = {mem_rdata[31:2], 2'b00};
                        2'd2: d.tag_t = mem_rdata;
                        default: begin
                            d.sh_buf = q.buf_a;
                            d.sh_tag = q.tag_t;
                            d.sh_cmd = mem_rdata;
                            d.remain = cmd_len;
                            d.pal    = mem_rdata[CMD_PAL];
                            d.eof_f  = mem_rdata[CMD_EOF];
                            sof_evt  = mem_rdata[CMD_SOF];
                            if (cmd_len == '0) begin
                                eof_evt = mem_rdata[CMD_EOF];
                                d.desc  = q.link;
                                d.st    = run ? ST_DREQ : ST_IDLE;
                            end else begin
                                d.blen = clip(cmd_len, bw);
                                d.st   = ST_FREQ;
                            end
                        end
                    endcase
                end
            end
            ST_FREQ: begin
                mem_addr = q.buf_a;
                mem_len  = q.blen;
                mem_req  = (room >= CW'(q.blen));
                if (mem_req && mem_gnt) begin
                    d.left = q.blen;
                    d.st   = ST_FBEAT;
                end
            end
            ST_FBEAT: begin
                if (mem_rvalid) begin
                    push     = 1'b1;
                    d.buf_a  = q.buf_a + 32'd4;
                    d.remain = q.remain - LEN_W'(1);
                    d.left   = q.left - BLEN_W'(1);
                    if (q.left == BLEN_W'(1)) begin
                        if (q.remain == LEN_W'(1)) begin
                            eof_evt = q.eof_f;
                            d.desc  = q.link;
                            d.st    = run ? ST_DREQ : ST_IDLE;
                        end else if (run) begin
                            d.blen = clip(q.remain - LEN_W'(1), bw);
                            d.st   = ST_FREQ;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign push_pal     = q.pal;
    assign frame_active = (q.st == ST_FREQ) || (q.st == ST_FBEAT);
    assign sh_buf       = q.sh_buf;
    assign sh_tag       = q.sh_tag;
    assign sh_cmd       = q.sh_cmd;

    p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_len)))
        else $error("request dropped or changed before grant");

    p_len_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && q.st == ST_FREQ) |->
            (mem_len != '0 && LEN_W'(mem_len) <= q.remain && mem_len <= BLEN_W'(MAX_BURST)))
        else $error("data burst exceeds remaining words");

endmodule

// File: rtl/fdf_regs.sv
`timescale 1ns/1ps
module fdf_regs
    import fdf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic [31:0] sh_buf,
    input  logic [31:0] sh_tag,
    input  logic [31:0] sh_cmd,
    input  logic        sof_evt,
    input  logic        eof_evt,
    input  logic        unf_evt,
    output logic        run,
    output logic [1:0]  burst_sel,
    output logic [31:0] desc_ptr,
    output logic        irq
);
    typedef struct packed {
        logic [31:0] ctrl;
        logic [31:0] ptr;
        logic [2:0]  sts;
    } regs_t;

    regs_t q, d;
    logic [2:0] set_v;
    logic [2:0] clr_v;

    always_comb begin
        d     = q;
        clr_v = 3'b000;
        set_v[STS_SOF] = sof_evt & q.ctrl[CTL_SOF_IE];
        set_v[STS_EOF] = eof_evt & q.ctrl[CTL_EOF_IE];
        set_v[STS_UNF] = unf_evt & q.ctrl[CTL_UNF_IE];
        if (reg_wr) begin
            case (reg_addr)
                RX_CTRL: d.ctrl = reg_wdata & CTL_MASK;
                RX_PTR:  d.ptr  = {reg_wdata[31:2], 2'b00};
                RX_STS:  clr_v  = reg_wdata[2:0];
                default: ;
            endcase
        end
        d.sts = (q.sts & ~clr_v) | set_v;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (reg_addr)
            RX_CTRL: reg_rdata = q.ctrl;
            RX_PTR:  reg_rdata = q.ptr;
            RX_STS:  reg_rdata = {29'd0, q.sts};
            RX_SBUF: reg_rdata = sh_buf;
            RX_STAG: reg_rdata = sh_tag;
            RX_SCMD: reg_rdata = sh_cmd;
            default: reg_rdata = 32'd0;
        endcase
    end

    assign run       = q.ctrl[CTL_RUN];
    assign burst_sel = q.ctrl[CTL_BSZ_LO+1:CTL_BSZ_LO];
    assign desc_ptr  = q.ptr;
    assign irq       = |q.sts;

    p_sof_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sts[STS_SOF] && !$past(q.sts[STS_SOF])) |-> $past(q.ctrl[CTL_SOF_IE]))
        else $error("start-of-frame status set while disabled");

    p_eof_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sts[STS_EOF] && !$past(q.sts[STS_EOF])) |-> $past(q.ctrl[CTL_EOF_IE]))
        else $error("end-of-frame status set while disabled");

    p_unf_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sts[STS_UNF] && !$past(q.sts[STS_UNF])) |-> $past(q.ctrl[CTL_UNF_IE]))
        else $error("underrun status set while disabled");

    p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == RX_STS && reg_wdata[STS_EOF] && !eof_evt) |=> !q.sts[STS_EOF])
        else $error("write-one clear did not clear status");

endmodule

// File: rtl/frame_desc_fetcher.sv
`timescale 1ns/1ps
module frame_desc_fetcher
    import fdf_pkg::*;
#(
    parameter int LEN_W      = 24,
    parameter int FIFO_DEPTH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic [31:0]       mem_addr,
    output logic [BLEN_W-1:0] mem_len,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    output logic              out_valid,
    output logic [31:0]       out_data,
    output logic              out_pal,
    input  logic              out_ready,
    output logic              irq
);
    localparam int CW = $clog2(FIFO_DEPTH + 1);
    localparam int FW = 33;

    logic          run;
    logic [1:0]    burst_sel;
    logic [31:0]   desc_ptr;
    logic [CW-1:0] fifo_cnt;
    logic          push, push_pal, pop;
    logic          sof_evt, eof_evt, unf_evt, frame_active;
    logic [31:0]   sh_buf, sh_tag, sh_cmd;
    logic [FW-1:0] head;
    logic          empty, full;

    fdf_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .sh_buf    (sh_buf),
        .sh_tag    (sh_tag),
        .sh_cmd    (sh_cmd),
        .sof_evt   (sof_evt),
        .eof_evt   (eof_evt),
        .unf_evt   (unf_evt),
        .run       (run),
        .burst_sel (burst_sel),
        .desc_ptr  (desc_ptr),
        .irq       (irq)
    );

    fdf_engine #(
        .LEN_W      (LEN_W),
        .FIFO_DEPTH (FIFO_DEPTH)
    ) u_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .run          (run),
        .burst_sel    (burst_sel),
        .desc_ptr     (desc_ptr),
        .fifo_cnt     (fifo_cnt),
        .mem_req      (mem_req),
        .mem_addr     (mem_addr),
        .mem_len      (mem_len),
        .mem_gnt      (mem_gnt),
        .mem_rvalid   (mem_rvalid),
        .mem_rdata    (mem_rdata),
        .push         (push),
        .push_pal     (push_pal),
        .sof_evt      (sof_evt),
        .eof_evt      (eof_evt),
        .frame_active (frame_active),
        .sh_buf       (sh_buf),
        .sh_tag       (sh_tag),
        .sh_cmd       (sh_cmd)
    );

    fdf_fifo #(
        .W     (FW),
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .wdata ({push_pal, mem_rdata}),
        .pop   (pop),
        .rdata (head),
        .empty (empty),
        .full  (full),
        .count (fifo_cnt)
    );

    assign out_valid = !empty;
    assign out_data  = head[31:0];
    assign out_pal   = head[32];
    assign pop       = out_valid && out_ready;
    assign unf_evt   = frame_active && out_ready && empty;

endmodule

// File: tb/tb_frame_desc_fetcher.sv
`timescale 1ns/1ps
module tb_frame_desc_fetcher;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic [4:0]  mem_len;
    logic        mem_gnt = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = 32'd0;
    logic        out_valid;
    logic [31:0] out_data;
    logic        out_pal;
    logic        out_ready = 1'b0;
    logic        irq;

    frame_desc_fetcher dut (.*);

    always #2.5 clk = ~clk;

    int checks = 0, errors = 0;
    int pops = 0, data_beats = 0, max_len = 0, last_len = 0, req_seen = 0;
    int rdy_mode = 0;
    logic [31:0] mem [512];
    logic [32:0] exp_q [$];

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rd(input logic [31:0] idx);
        return (idx < 512) ? mem[idx[8:0]] : 32'd0;
    endfunction

    // memory model: grant, one gap after the first beat, one beat per word
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req) begin
                logic [31:0] a;
                int n;
                req_seen++;
                a = mem_addr;
                n = int'(mem_len);
                mem_gnt = 1'b1;
                @(negedge clk);
                mem_gnt = 1'b0;
                if (a >= 32'h100) begin
                    last_len = n;
                    if (n > max_len) max_len = n;
                end
                for (int k = 0; k < n; k++) begin
                    if (k == 1) begin
                        mem_rvalid = 1'b0;
                        @(negedge clk);
                    end
                    mem_rvalid = 1'b1;
                    mem_rdata  = rd((a >> 2) + 32'(k));
                    if (a >= 32'h100) data_beats++;
                    @(negedge clk);
                end
                mem_rvalid = 1'b0;
            end
        end
    end

    // consumer and scoreboard monitor
    initial begin
        int cyc = 0;
        forever begin
            @(negedge clk);
            cyc++;
            out_ready = (rdy_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
            #1;
            if (out_valid && out_ready && rst_n) begin
                pops++;
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R3 unexpected word actual %h expected none", out_data);
                end else begin
                    logic [32:0] e;
                    e = exp_q.pop_front();
                    if ({out_pal, out_data} !== e) begin
                        errors++;
                        $display("FAIL R3/R10/R12 stream actual %h expected %h",
                                 {out_pal, out_data}, e);
                    end
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic reg_write(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic set_desc(input int at, input logic [31:0] link, input logic [31:0] bufa,
                            input logic [31:0] tag, input logic [31:0] cmd);
        mem[at/4]     = link;
        mem[at/4 + 1] = bufa;
        mem[at/4 + 2] = tag;
        mem[at/4 + 3] = cmd;
    endtask

    task automatic expect_frame(input int bufa, input int len, input logic pal);
        for (int i = 0; i < len; i++) exp_q.push_back({pal, mem[bufa/4 + i]});
    endtask

    task automatic wait_pops(input int target);
        for (int i = 0; i < 20000 && pops < target; i++) @(negedge clk);
    endtask

    task automatic stop_and_clear();
        reg_write(3'd0, 32'd0);
        repeat (80) @(negedge clk);
        reg_write(3'd2, 32'd7);
        pops = 0; data_beats = 0; max_len = 0; last_len = 0;
    endtask

    initial begin
        logic [31:0] v;
        for (int i = 0; i < 512; i++) mem[i] = (i >= 64) ? (32'hC0DE_0000 + 32'(i)) : 32'd0;
        // A -> B -> Z, Z links to itself with a count of 0
        set_desc(32'h000, 32'h010, 32'h100, 32'h5A5A_0001, 32'hC000_000B);
        set_desc(32'h010, 32'h020, 32'h200, 32'h5A5A_0002, 32'h1000_000D);
        set_desc(32'h020, 32'h020, 32'h0AB0, 32'h5A5A_0003, 32'h0000_0000);
        set_desc(32'h030, 32'h030, 32'h300, 32'h5A5A_0004, 32'h8000_0014);
        set_desc(32'h040, 32'h020, 32'h400, 32'h5A5A_0005, 32'hC000_0025);

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "out_valid", 32'(out_valid), 32'd0);
        chk("R1", "mem_req", 32'(mem_req), 32'd0);
        chk("R1", "irq", 32'(irq), 32'd0);
        reg_read(3'd0, v); chk("R1", "ctrl", v, 32'd0);
        reg_read(3'd2, v); chk("R1", "status", v, 32'd0);

        // Test 1: burst 4, SOF/EOF enabled, backpressure
        rdy_mode = 1;
        expect_frame(32'h100, 11, 1'b0);
        expect_frame(32'h200, 13, 1'b1);
        reg_write(3'd1, 32'h000);
        reg_write(3'd0, 32'h0000_3001);
        wait_pops(24);
        repeat (60) @(negedge clk);
        chk("R3", "words streamed", 32'(pops), 32'd24);
        chk("R6", "data beats read", 32'(data_beats), 32'd24);
        chk("R5", "largest burst sel0", 32'(max_len), 32'd4);
        chk("R6", "last burst of B", 32'(last_len), 32'd1);
        reg_read(3'd3, v); chk("R2", "shadow buffer", v, 32'h0000_0AB0);
        reg_read(3'd4, v); chk("R2", "shadow tag", v, 32'h5A5A_0003);
        reg_read(3'd5, v); chk("R4", "shadow cmd after link", v, 32'd0);
        reg_read(3'd2, v); chk("R7", "status sof+eof, R8 unf ignored", v, 32'd3);
        chk("R9", "irq set", 32'(irq), 32'd1);
        reg_write(3'd2, 32'd1);
        reg_read(3'd2, v); chk("R9", "clear sof only", v, 32'd2);
        reg_write(3'd2, 32'd2);
        reg_read(3'd2, v); chk("R9", "clear eof", v, 32'd0);
        chk("R9", "irq low", 32'(irq), 32'd0);
        reg_write(3'd0, 32'd0);
        repeat (60) @(negedge clk);
        req_seen = 0;
        repeat (100) @(negedge clk);
        chk("R11", "requests after disable", 32'(req_seen), 32'd0);
        chk("R11", "stream idle", 32'(out_valid), 32'd0);
        stop_and_clear();

        // Test 2: burst 8, flags set but SOF/EOF enables off, underrun on
        rdy_mode = 0;
        expect_frame(32'h100, 11, 1'b0);
        expect_frame(32'h200, 13, 1'b1);
        reg_write(3'd0, 32'h1000_0801);
        wait_pops(24);
        repeat (60) @(negedge clk);
        chk("R3", "words streamed t2", 32'(pops), 32'd24);
        chk("R5", "largest burst sel1", 32'(max_len), 32'd8);
        chk("R6", "last burst of B t2", 32'(last_len), 32'd5);
        reg_read(3'd2, v); chk("R8", "underrun only", v, 32'd4);
        stop_and_clear();

        // Test 3: burst 16, 37-word frame
        reg_write(3'd1, 32'h040);
        expect_frame(32'h400, 37, 1'b0);
        reg_write(3'd0, 32'h2000_2001);
        wait_pops(37);
        repeat (60) @(negedge clk);
        chk("R3", "words streamed t3", 32'(pops), 32'd37);
        chk("R5", "largest burst sel2", 32'(max_len), 32'd16);
        chk("R6", "shortened last burst", 32'(last_len), 32'd5);
        chk("R6", "data beats t3", 32'(data_beats), 32'd37);
        reg_read(3'd2, v); chk("R7", "eof only", v, 32'd2);
        stop_and_clear();

        // Test 4: self-linked frame repeats until disabled
        reg_write(3'd1, 32'h030);
        for (int f = 0; f < 6; f++) expect_frame(32'h300, 20, 1'b0);
        reg_write(3'd0, 32'h1000_1001);
        wait_pops(45);
        reg_write(3'd0, 32'd0);
        repeat (300) @(negedge clk);
        checks++;
        if (pops < 45) begin
            errors++;
            $display("FAIL R4 repeated words actual %0d expected >= 45", pops);
        end
        chk("R12", "all fetched words delivered", 32'(pops), 32'(data_beats));
        reg_read(3'd4, v); chk("R2", "shadow tag repeat", v, 32'h5A5A_0004);
        reg_read(3'd5, v); chk("R2", "shadow cmd repeat", v, 32'h8000_0014);
        reg_read(3'd2, v); chk("R7", "sof bit", v & 32'd1, 32'd1);
        exp_q.delete();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule